// File: doc/BRIEF.md
# Low-Discrepancy Stochastic Bitstream Generator

This block feeds a stochastic computing datapath with several unary bitstreams at once. One binary up counter steps through 2^n states. For each channel, fixed wiring reorders the counter's digits in base 2^k, which gives a Van der Corput low-discrepancy sequence. A magnitude comparator tests that sequence against the channel's binary value. Each stream carries one bit per cycle, and the share of ones in a full period equals value / 2^n.

Channel c uses digit groups of c mod 4 + 1 bits. That gives bases 2, 4, 8 and 16 in turn. Extra channels add comparators only. Streams from different bases are not generated independently: they are distinct reorderings of the same counter, so no per-stream random source or decorrelator is needed. A ones-counting decoder attached to one selected stream turns it back into a binary count over the period.

A start pulse clears the counter and the decoder and begins a period. When n is not a multiple of the group size, the leftover top bits go, in their original order, to the least significant end of the sequence. With the default n = 12 this case does not occur.

Top module: `ldsg_bitstream_gen`

## Requirements
- R1: While reset is held and after its release, with no start given, every `stream_o` bit, `done_o` and `count_o` are 0.
- R2: A start pulse clears the counter and the decoded count. The first stream bit appears in the cycle after the start edge, and a period then lasts exactly 2^n cycles.
- R3: In the cycle where the counter holds value t, bit c of `stream_o` is 1 exactly when rev_k(t) < `value_i[c]`. Here k = c mod 4 + 1, and rev_k reverses the order of the k-bit digit groups of t while keeping the bit order inside each group. For k = 1 this is a full bit reversal.
- R4: `done_o` is high for exactly one cycle, the cycle after the last bit of a period. It is low throughout the period.
- R5: When `done_o` is high, `count_o` equals the number of ones in the selected stream over the period. This equals `value_i` of that channel, including the extremes 0 and 2^n-1.
- R6: A start in the same cycle as the last bit of a period restarts the period. No `done_o` follows, and `count_o` reads 0 in the next cycle.
- R7: Outside a period all streams are 0, and `count_o` holds its value until the next start.
- R8: `sel_i` is captured at start. Changing it during a period has no effect on the decoded count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new period, clearing counter and decoder |
| value_i | input | NUM_CH x CNT_W | Binary value per channel; must stay stable during a period |
| sel_i | input | SEL_W | Channel whose stream the decoder counts, captured at start |
| stream_o | output | NUM_CH | One stochastic bit per channel per cycle |
| count_o | output | CNT_W+1 | Ones counted on the selected stream |
| done_o | output | 1 | One-cycle pulse after the final bit of a period |

## Verification
A new start and the last bit of a period can land in the same cycle. That one cycle would then both finish the decoded count with a done pulse and clear everything for a new period. The bench provokes this by raising start while the counter shows its final state, using fresh values and a fresh channel. It then requires that no done pulse appears, that the count reads zero, and that the next stream bits follow the restarted counter. The scoreboard must then see exactly one decode result from the restarted period, and that result must carry the new channel's value.

// File: rtl/ldsg_pkg.sv
package ldsg_pkg;
  localparam int unsigned MAX_GRP = 4;

  // digit group width used by channel ch
  function automatic int unsigned grp_of(int unsigned ch);
    return (ch % MAX_GRP) + 1;
  endfunction
endpackage

// File: rtl/ldsg_digit_rev.sv
module ldsg_digit_rev #(
  parameter int unsigned W = 12,
  parameter int unsigned K = 1
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  localparam int unsigned G = W / K;
  localparam int unsigned R = W % K;

  for (genvar j = 0; j < G; j++) begin : g_grp
    assign out_o[R + (G-1-j)*K +: K] = in_i[j*K +: K];
  end

  if (R > 0) begin : g_part
    // leftover top digit goes unreversed to the bottom
    assign out_o[R-1:0] = in_i[W-1 -: R];
  end
endmodule

// File: rtl/ldsg_seq_ctrl.sv
module ldsg_seq_ctrl #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         run_o,
  output logic         last_o,
  output logic [W-1:0] cnt_o
);
  logic         run_q;
  logic [W-1:0] cnt_q;

  assign last_o = run_q && (cnt_q == {W{1'b1}});
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ldsg_decoder.sv
module ldsg_decoder #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         last_i,
  input  logic         bit_i,
  output logic [W:0]   count_o,
  output logic         done_o
);
  logic [W:0] acc_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= en_i && last_i;
      if (en_i && bit_i) acc_q <= acc_q + 1'b1;
    end
  end

  assign count_o = acc_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ldsg_bitstream_gen.sv
module ldsg_bitstream_gen #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   value_i,
  input  logic [SEL_W-1:0]               sel_i,
  output logic [NUM_CH-1:0]              stream_o,
  output logic [CNT_W:0]                 count_o,
  output logic                           done_o
);
  import ldsg_pkg::*;

  logic             run_q;
  logic             last;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_q;
  logic             sel_bit;

  ldsg_seq_ctrl #(.W(CNT_W)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .run_o  (run_q),
    .last_o (last),
    .cnt_o  (cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned K = grp_of(c);
    logic [CNT_W-1:0] seq;

    ldsg_digit_rev #(.W(CNT_W), .K(K)) i_rev (
      .in_i (cnt),
      .out_o(seq)
    );

    assign stream_o[c] = run_q && (seq < value_i[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (start_i) sel_q <= sel_i;
  end

  always_comb begin
    sel_bit = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (sel_q == SEL_W'(c)) sel_bit = stream_o[c];
  end

  ldsg_decoder #(.W(CNT_W)) i_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .en_i   (run_q),
    .last_i (last),
    .bit_i  (sel_bit),
    .count_o(count_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/ldsg_bitstream_gen_chk.sv
module ldsg_bitstream_gen_chk #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              run_q,
  input logic [NUM_CH-1:0] stream_o,
  input logic [CNT_W:0]    count_o,
  input logic              done_o
);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_o == '0) && !done_o);

  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_q && $past(run_q));

  a_r5_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> count_o <= {1'b1, {CNT_W{1'b0}}});

  a_r6_no_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> stream_o == '0);

  a_r7_count_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(count_o));
endmodule

bind ldsg_bitstream_gen ldsg_bitstream_gen_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .run_q   (run_q),
  .stream_o(stream_o),
  .count_o (count_o),
  .done_o  (done_o)
);

// File: tb/test_ldsg_bitstream_gen.sv
`timescale 1ns/1ps
module test_ldsg_bitstream_gen;
  localparam int W   = 12;
  localparam int NCH = 4;
  localparam int LEN = 1 << W;

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic                      start_i = 1'b0;
  logic [NCH-1:0][W-1:0]     value_i = '0;
  logic [1:0]                sel_i = '0;
  logic [NCH-1:0]            stream_o;
  logic [W:0]                count_o;
  logic                      done_o;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int dones_seen = 0;

  always #5 clk_i = ~clk_i;

  ldsg_bitstream_gen #(.CNT_W(W), .NUM_CH(NCH)) i_ldsg_bitstream_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .value_i(value_i),
    .sel_i(sel_i), .stream_o(stream_o), .count_o(count_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // digit-group reversal, group width k
  function automatic int vdc(input int t, input int k);
    int g = W / k;
    int r = W % k;
    int o = 0;
    for (int j = 0; j < g; j++)
      o |= ((t >> (j*k)) & ((1 << k) - 1)) << ((g-1-j)*k + r);
    if (r > 0) o |= t >> (W - r);
    return o;
  endfunction

  function automatic bit model_bit(input int t, input int c);
    return vdc(t, (c % 4) + 1) < int'(value_i[c]);
  endfunction

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      dones_seen++;
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected done", int'(count_o), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(count_o) == e, "R5 decoded count", int'(count_o), e);
      end
    end
  end

  task automatic pulse_start(input int sel);
    start_i = 1'b1;
    sel_i   = 2'(sel);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // samples every bit of one period; on abort, restarts at the last bit
  task automatic stream_pass(input int sel_mid, input bit abort,
                             input logic [NCH-1:0][W-1:0] nvals, input int nsel);
    int bad[NCH];
    int done_hi = 0;
    int and_act = 0, and_exp = 0;
    for (int c = 0; c < NCH; c++) bad[c] = 0;
    for (int i = 0; i < LEN; i++) begin
      if (i > 0) @(negedge clk_i);
      for (int c = 0; c < NCH; c++)
        if (stream_o[c] != model_bit(i, c)) bad[c]++;
      if (done_o) done_hi++;
      if (stream_o[0] && stream_o[2]) and_act++;
      if (model_bit(i, 0) && model_bit(i, 2)) and_exp++;
      if (i == LEN/2 && sel_mid >= 0) sel_i = 2'(sel_mid);
      if (abort && i == LEN-1) begin
        start_i = 1'b1;
        value_i = nvals;
        sel_i   = 2'(nsel);
      end
    end
    for (int c = 0; c < NCH; c++)
      check(bad[c] == 0, "R3 stream sequence mismatches", bad[c], 0);
    check(and_act == and_exp, "R3 base2 x base8 product count", and_act, and_exp);
    check(done_hi == 0, "R4 done low during period", done_hi, 0);
    if (abort) begin
      @(negedge clk_i);
      start_i = 1'b0;
      check(done_o == 1'b0, "R6 no done on restart", int'(done_o), 0);
      check(count_o == '0, "R6 count cleared on restart", int'(count_o), 0);
    end
  endtask

  task automatic full_run(input logic [NCH-1:0][W-1:0] vals, input int sel, input int sel_mid);
    logic [NCH-1:0][W-1:0] dummy = '0;
    value_i = vals;
    exp_q.push_back(int'(vals[sel]));
    pulse_start(sel);
    stream_pass(sel_mid, 1'b0, dummy, 0);
    @(negedge clk_i);
    check(done_o == 1'b1, "R2 R4 done one cycle after 2^n bits", int'(done_o), 1);
    @(negedge clk_i);
    check(done_o == 1'b0, "R4 done single cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NCH-1:0][W-1:0] a, b;
    int hold;
    repeat (3) @(negedge clk_i);
    check(stream_o == '0 && done_o == 1'b0 && count_o == '0, "R1 reset state", int'(stream_o), 0);
    rst_ni = 1'b1;
    value_i = {12'd4095, 12'd37, 12'd2500, 12'd1000};
    repeat (3) @(negedge clk_i);
    check(stream_o == '0 && done_o == 1'b0 && count_o == '0, "R1 idle after reset", int'(count_o), 0);

    full_run({12'd4095, 12'd37, 12'd2500, 12'd1000}, 0, -1);
    // R7: outside period, quiet streams and held count
    hold = int'(count_o);
    repeat (5) @(negedge clk_i);
    check(stream_o == '0, "R7 streams idle", int'(stream_o), 0);
    check(int'(count_o) == hold, "R7 count held", int'(count_o), hold);

    full_run({12'd1, 12'd2048, 12'd4095, 12'd0}, 1, -1);
    full_run({12'd1, 12'd2048, 12'd4095, 12'd0}, 3, -1);
    full_run({12'd777, 12'd3333, 12'd1234, 12'd0}, 0, -1);
    // R8: sel changed mid period
    full_run({12'd99, 12'd3000, 12'd1500, 12'd2222}, 2, 0);

    // R6: start coinciding with final bit
    a = {12'd100, 12'd200, 12'd300, 12'd400};
    b = {12'd2731, 12'd5, 12'd4000, 12'd17};
    value_i = a;
    pulse_start(1);
    stream_pass(-1, 1'b1, b, 3);
    exp_q.push_back(int'(b[3]));
    stream_pass(-1, 1'b0, a, 0);
    @(negedge clk_i);
    check(done_o == 1'b1, "R6 done after restarted period", int'(done_o), 1);
    repeat (3) @(negedge clk_i);

    check(exp_q.size() == 0, "R5 all decodes seen", exp_q.size(), 0);
    check(dones_seen == 6, "R6 done count", dones_seen, 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule